// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It does so by reading two entries from memory. The first is a directory entry, found from a root frame supplied on a control input. The second is a table entry, found from the frame held in the directory entry. Pages are 4 KB, and the low 12 address bits pass straight through to the physical address.

Each request carries the virtual address, a write flag and a user-mode flag. At each level the walker checks that the entry is present and that it permits the access. A not-present entry and a permission violation are reported as different fault kinds, along with the level where the walk stopped. When the walk succeeds, the walker sets the accessed bit in both entries and, for a write, the dirty bit in the table entry. It writes an entry back to memory only when that entry's value actually changes.

The request side is a valid/ready stream. `req_ready` is high only while the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester may hold `req_valid` high for as long as it likes, and the address and flags are only sampled on the accepting edge. There is no back-pressure on the result: `done` is a single-cycle pulse and the result fields are valid only in that cycle. The memory port returns read data on the cycle after `mem_rd_en`, and writes take effect on the edge where `mem_wr_en` is high.

Top module: `ptw_walker`

## Requirements
- R1: The directory entry is read from {root_frame, va[31:22], 2'b00} and the table entry from {dir_entry[31:12], va[21:12], 2'b00}. On success, res_paddr = {tbl_entry[31:12], va[11:0]}.
- R2: If the directory entry has bit 0 (present) clear, the result is res_fault=1 (not present) with res_level=0. No table entry is read.
- R3: If the directory entry passes its checks but the table entry has bit 0 clear, the result is res_fault=1 with res_level=1.
- R4: A write is denied unless entry bit 1 is set, and a user access (req_user=1) is denied unless entry bit 2 is set. The check is applied to the directory entry first and then to the table entry. A denial gives res_fault=2 (protection) with res_level equal to the level of the entry that denied it. Supervisor reads ignore both bits.
- R5: On success, bit 5 (accessed) becomes 1 in both entries. An entry is written back only when its value changes, the directory entry before the table entry.
- R6: On a successful write, bit 6 (dirty) of the table entry becomes 1. The directory entry's bit 6 is never modified, and no bit is ever cleared.
- R7: A faulting walk performs no memory write.
- R8: req_ready is high only while idle, and done is a one-cycle pulse. Counting the accepting edge as edge 0, done is high after edge 2 for a directory-level fault, after edge 4 for a table-level fault, and after edge 4 plus the number of write-backs for a successful walk.
- R9: On success, res_pwt and res_pcd equal bits 3 and 4 of the table entry.
- R10: After reset, req_ready=1, done=0, and the memory port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | 20 | Physical frame of the directory |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory word address (byte address, 4-aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd_en |
| done | output | 1 | One-cycle result pulse |
| res_paddr | output | 32 | Translated physical address |
| res_fault | output | 2 | 0 none, 1 not present, 2 protection |
| res_level | output | 1 | 0 directory, 1 table |
| res_pwt | output | 1 | Write-through attribute of the page |
| res_pcd | output | 1 | Cache-disable attribute of the page |

## Verification
The hardest cases to reach are those that depend on the state of the status bits in memory. Examples are a walk that writes back only the table entry, or one that writes nothing because both accessed bits and the dirty bit are already set. Another is a walk where the directory entry alone denies the access while the table entry would allow it. The bench reaches these by preloading the memory model with entries whose accessed and dirty bits are set or clear as each case needs. It also repeats walks to the same page, so the second walk meets bits that the first walk set. A change of root frame midway checks that entry addresses follow the control input.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W  = 32;
  localparam int OFS_W   = 12;
  localparam int IDX_W   = 10;
  localparam int FRAME_W = ADDR_W - OFS_W;
  localparam int LEVELS  = 2;

  localparam int B_PRES  = 0;
  localparam int B_RW    = 1;
  localparam int B_US    = 2;
  localparam int B_PWT   = 3;
  localparam int B_PCD   = 4;
  localparam int B_ACC   = 5;
  localparam int B_DIRTY = 6;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_NOTPRES = 2'd1,
    FLT_PROT    = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_CHK_DIR, ST_RD_TBL, ST_CHK_TBL,
    ST_WB_DIR, ST_WB_TBL, ST_DONE
  } walk_st_e;
endpackage

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk (
  input  logic [2:0] flags,
  input  logic       is_write,
  input  logic       is_user,
  output logic       present,
  output logic       allowed
);
  import ptw_pkg::*;
  always_comb begin
    present = flags[B_PRES];
    allowed = !(is_write && !flags[B_RW]) && !(is_user && !flags[B_US]);
  end
endmodule

// File: rtl/ptw_status_upd.sv
module ptw_status_upd #(
  parameter int  ENTRY_W = 32,
  parameter bit  IS_LEAF = 1'b0
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic               is_write,
  output logic [ENTRY_W-1:0] new_entry,
  output logic               changed
);
  import ptw_pkg::*;
  always_comb begin
    new_entry = entry;
    new_entry[B_ACC] = 1'b1;
    if (IS_LEAF && is_write) new_entry[B_DIRTY] = 1'b1;
    changed = (new_entry != entry);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FRAME_W-1:0]   root_frame,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_vaddr,
  input  logic                 req_write,
  input  logic                 req_user,
  output logic                 mem_rd_en,
  output logic                 mem_wr_en,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [ADDR_W-1:0]    mem_wdata,
  input  logic [ADDR_W-1:0]    mem_rdata,
  output logic                 done,
  output logic [ADDR_W-1:0]    res_paddr,
  output logic [1:0]           res_fault,
  output logic                 res_level,
  output logic                 res_pwt,
  output logic                 res_pcd
);
  localparam int HI_LO = OFS_W + IDX_W;

  walk_st_e            state;
  logic [ADDR_W-1:0]   va_q;
  logic                wr_q, us_q;
  logic [FRAME_W-1:0]  base_q;
  logic [ADDR_W-1:0]   pde_q, pte_q;
  fault_e              fault_q;

  logic [ADDR_W-1:0]   dir_addr, tbl_addr;
  logic                ent_present, ent_allowed;
  logic [ADDR_W-1:0]   lvl_in  [LEVELS];
  logic [ADDR_W-1:0]   lvl_out [LEVELS];
  logic [LEVELS-1:0]   lvl_chg;

  assign dir_addr = {base_q, va_q[ADDR_W-1:HI_LO], 2'b00};
  assign tbl_addr = {pde_q[ADDR_W-1:OFS_W], va_q[HI_LO-1:OFS_W], 2'b00};

  ptw_perm_chk u_perm (
    .flags    (mem_rdata[2:0]),
    .is_write (wr_q),
    .is_user  (us_q),
    .present  (ent_present),
    .allowed  (ent_allowed)
  );

  assign lvl_in[0] = pde_q;
  assign lvl_in[1] = (state == ST_CHK_TBL) ? mem_rdata : pte_q;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_upd
    ptw_status_upd #(.ENTRY_W(ADDR_W), .IS_LEAF(lv == LEVELS-1)) u_upd (
      .entry     (lvl_in[lv]),
      .is_write  (wr_q),
      .new_entry (lvl_out[lv]),
      .changed   (lvl_chg[lv])
    );
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    done      = (state == ST_DONE);
    mem_rd_en = (state == ST_RD_DIR) || (state == ST_RD_TBL);
    mem_wr_en = (state == ST_WB_DIR) || (state == ST_WB_TBL);
    mem_addr  = ((state == ST_RD_DIR) || (state == ST_WB_DIR)) ? dir_addr : tbl_addr;
    mem_wdata = (state == ST_WB_DIR) ? lvl_out[0] : lvl_out[1];
    res_fault = fault_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      va_q      <= '0;
      wr_q      <= 1'b0;
      us_q      <= 1'b0;
      base_q    <= '0;
      pde_q     <= '0;
      pte_q     <= '0;
      fault_q   <= FLT_NONE;
      res_level <= 1'b0;
      res_paddr <= '0;
      res_pwt   <= 1'b0;
      res_pcd   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          va_q      <= req_vaddr;
          wr_q      <= req_write;
          us_q      <= req_user;
          base_q    <= root_frame;
          fault_q   <= FLT_NONE;
          res_level <= 1'b0;
          res_paddr <= '0;
          res_pwt   <= 1'b0;
          res_pcd   <= 1'b0;
          state     <= ST_RD_DIR;
        end
        ST_RD_DIR: state <= ST_CHK_DIR;
        ST_CHK_DIR: begin
          pde_q <= mem_rdata;
          if (!ent_present) begin
            fault_q <= FLT_NOTPRES;
            state   <= ST_DONE;
          end else if (!ent_allowed) begin
            fault_q <= FLT_PROT;
            state   <= ST_DONE;
          end else begin
            state <= ST_RD_TBL;
          end
        end
        ST_RD_TBL: state <= ST_CHK_TBL;
        ST_CHK_TBL: begin
          pte_q     <= mem_rdata;
          res_level <= 1'b1;
          if (!ent_present) begin
            fault_q <= FLT_NOTPRES;
            state   <= ST_DONE;
          end else if (!ent_allowed) begin
            fault_q <= FLT_PROT;
            state   <= ST_DONE;
          end else begin
            res_level <= 1'b0;
            res_paddr <= {mem_rdata[ADDR_W-1:OFS_W], va_q[OFS_W-1:0]};
            res_pwt   <= mem_rdata[B_PWT];
            res_pcd   <= mem_rdata[B_PCD];
            if (lvl_chg[0])      state <= ST_WB_DIR;
            else if (lvl_chg[1]) state <= ST_WB_TBL;
            else                 state <= ST_DONE;
          end
        end
        ST_WB_DIR: state <= lvl_chg[1] ? ST_WB_TBL : ST_DONE;
        ST_WB_TBL: state <= ST_DONE;
        ST_DONE:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R8: result pulse lasts exactly one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8, R10: an idle walker leaves memory untouched
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_en && !mem_wr_en));
  // R5: every write-back carries the accessed bit
  a_r5_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_wdata[B_ACC]);
  // R7: write-back only after all reads of the walk
  a_r7_no_read_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> !mem_rd_en);
  // R2: fault code stays within the defined set
  a_r2_fault_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_fault != 2'd3));
  // R7: a fault is never reported right after a write-back
  a_r7_fault_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault != 2'd0) |-> !$past(mem_wr_en));
endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] root_frame;
  logic        req_valid, req_ready, req_write, req_user;
  logic [31:0] req_vaddr;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, res_level, res_pwt, res_pcd;
  logic [31:0] res_paddr;
  logic [1:0]  res_fault;

  always #5 clk = ~clk;

  ptw_walker i_ptw_walker (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] obs_rd[$];
  logic [31:0] obs_wa[$];
  logic [31:0] obs_wd[$];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and per-clock observation
  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_rd_en) begin
        mem_rdata <= rd(mem_addr);
        obs_rd.push_back(mem_addr);
      end
      if (mem_wr_en) begin
        mem[mem_addr] = mem_wdata;
        obs_wa.push_back(mem_addr);
        obs_wd.push_back(mem_wdata);
      end
      if (req_ready && (mem_rd_en || mem_wr_en))
        chk(0, "R8 memory active while idle", {30'd0, mem_rd_en, mem_wr_en}, 32'd0);
    end
  end

  task automatic walk(input logic [31:0] va, input bit w, input bit u, input string tag);
    logic [31:0] da, ta, pde, pte, npde, npte, pa;
    logic [31:0] e_rd[$];
    logic [31:0] e_wa[$];
    logic [31:0] e_wd[$];
    int f, l, lat, k;
    pa = 0; ta = 0; pte = 0; f = 0; l = 0;
    da = {root_frame, va[31:22], 2'b00};
    pde = rd(da);
    e_rd.push_back(da);
    if (!pde[0]) begin f = 1; l = 0; lat = 2; end
    else if ((w && !pde[1]) || (u && !pde[2])) begin f = 2; l = 0; lat = 2; end
    else begin
      ta = {pde[31:12], va[21:12], 2'b00};
      pte = rd(ta);
      e_rd.push_back(ta);
      lat = 4;
      if (!pte[0]) begin f = 1; l = 1; end
      else if ((w && !pte[1]) || (u && !pte[2])) begin f = 2; l = 1; end
      else begin
        pa = {pte[31:12], va[11:0]};
        npde = pde | 32'h20;
        npte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
        if (npde != pde) begin e_wa.push_back(da); e_wd.push_back(npde); lat++; end
        if (npte != pte) begin e_wa.push_back(ta); e_wd.push_back(npte); lat++; end
      end
    end
    obs_rd.delete(); obs_wa.delete(); obs_wd.delete();
    @(negedge clk);
    req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    k = 0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      if (done || k > 20) break;
      @(posedge clk);
      k++;
    end
    chk(done, {tag, " R8 done seen"}, {31'd0, done}, 32'd1);
    chk(k == lat, {tag, " R8 latency"}, k, lat);
    chk(res_fault == f[1:0], {tag, f == 1 ? (l == 0 ? " R2" : " R3") : (f == 2 ? " R4" : " R1"), " fault code"}, res_fault, f);
    if (f != 0) chk(res_level == l[0], {tag, l == 0 ? " R2/R4 level" : " R3/R4 level"}, res_level, l);
    if (f == 0) begin
      chk(res_paddr == pa, {tag, " R1 paddr"}, res_paddr, pa);
      chk(res_pwt == pte[3] && res_pcd == pte[4], {tag, " R9 attributes"}, {res_pcd, res_pwt}, {pte[4], pte[3]});
      chk(obs_wa.size() == e_wa.size(), {tag, " R5 write count"}, obs_wa.size(), e_wa.size());
      for (int i = 0; i < e_wa.size() && i < obs_wa.size(); i++) begin
        chk(obs_wa[i] == e_wa[i], {tag, " R5 write address"}, obs_wa[i], e_wa[i]);
        chk(obs_wd[i] == e_wd[i], {tag, " R6 write data"}, obs_wd[i], e_wd[i]);
      end
      chk(rd(ta)[6] == (w | pte[6]), {tag, " R6 dirty in table entry"}, rd(ta), pte | (w ? 32'h40 : 0));
      chk(rd(da)[6] == pde[6], {tag, " R6 directory dirty untouched"}, rd(da), pde | 32'h20);
    end else begin
      chk(obs_wa.size() == 0, {tag, " R7 no write on fault"}, obs_wa.size(), 0);
    end
    chk(obs_rd.size() == e_rd.size(), {tag, " R1 read count"}, obs_rd.size(), e_rd.size());
    for (int i = 0; i < e_rd.size() && i < obs_rd.size(); i++)
      chk(obs_rd[i] == e_rd[i], {tag, " R1 read address"}, obs_rd[i], e_rd[i]);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired R8 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_user = 1'b0;
    root_frame = 20'h00100; mem_rdata = '0;
    // directory at 0x00100000
    mem[32'h00100004] = 32'h00200007;  // user RW table at 0x00200000, A clear
    mem[32'h0020_0004] = 32'h0034500F; // user RW page, PWT set
    mem[32'h0020_0008] = 32'h00346005; // user read-only page
    mem[32'h0010_000C] = 32'h00300003; // supervisor-only directory entry
    mem[32'h0030_0000] = 32'h00400017; // user RW page, PCD set
    mem[32'h0010_0010] = 32'h00500005; // read-only directory entry
    mem[32'h0050_0000] = 32'h00600007;
    mem[32'h0070_0004] = 32'h00800027; // second root: accessed already set
    mem[32'h0080_0004] = 32'h00900067; // accessed and dirty set
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready in reset", req_ready, 1);
    chk(done == 1'b0, "R10 done low in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !mem_rd_en && !mem_wr_en, "R10 idle after reset",
        {28'd0, req_ready, done, mem_rd_en, mem_wr_en}, 32'h8);

    walk(32'h0040_1234, 0, 1, "user read, both A clear");   // R5: two writes
    walk(32'h0040_1234, 0, 1, "repeat read");               // R5: no writes
    walk(32'h0040_1ABC, 1, 1, "user write");                // R6: table entry only
    walk(32'h0080_0000, 0, 0, "directory absent");          // R2
    walk(32'h0040_3000, 0, 0, "table absent");              // R3
    walk(32'h0040_2ABC, 1, 1, "write read-only page");      // R4 level 1
    walk(32'h0040_2ABC, 0, 1, "read read-only page");       // R5 success
    walk(32'h00C0_0010, 0, 1, "user on supervisor dir");    // R4 level 0
    walk(32'h00C0_0010, 0, 0, "supervisor read");           // R9 PCD
    walk(32'h00C0_0010, 1, 0, "supervisor write");          // R6
    walk(32'h0100_0000, 1, 0, "write via read-only dir");   // R4 level 0
    walk(32'h0100_0000, 0, 1, "user read via read-only dir");
    root_frame = 20'h00700;
    walk(32'h0040_1234, 0, 0, "new root, bits set");        // R1, R5 no writes
    walk(32'h0040_1234, 1, 1, "new root write, dirty set"); // R6 nothing changes

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule